// File: doc/BRIEF.md
# Next-PC selection unit

This combinational block produces the address of the next instruction for a single-cycle processor. It takes the current program counter, the fetched instruction word, the decoded jump and branch controls, a 2-bit branch condition code and the two register operand values. From these it returns the next program counter and a flag that reports whether a conditional branch was taken.

Selection happens in two levels. The first level checks the branch. It picks the branch target when the branch flag is set and the chosen condition holds, and PC+4 in every other case. The second level gives the jump target priority over that first result. A jump keeps the top bits of PC+4 and fills the rest with the instruction's 26-bit index followed by two zero bits. A branch adds the sign-extended 16-bit offset, scaled by four, to PC+4. All arithmetic wraps modulo 2^32.

Top module: `npc_unit`

## Requirements
- R1: With jump_i high, next_pc_o is {PC+4[31:28], instr_i[25:0], 2'b00}, where PC+4 is the wrapped sum of pc_i and 4.
- R2: With jump_i low and br_taken_o high, next_pc_o equals PC+4 plus sign-extended instr_i[15:0] shifted left by two, modulo 2^32.
- R3: jump_i has priority over a taken branch. br_taken_o still reports the branch condition when jump_i is high.
- R4: With jump_i low and br_taken_o low, next_pc_o equals PC+4.
- R5: Condition code 2'b00 (equal) is met when rs_val_i equals rt_val_i.
- R6: Condition code 2'b01 (not equal) is met when rs_val_i differs from rt_val_i.
- R7: Condition code 2'b10 is met when rs_val_i, read as signed two's complement, is less than or equal to zero. rt_val_i has no effect.
- R8: Condition code 2'b11 is met when rs_val_i, read as signed two's complement, is greater than zero. rt_val_i has no effect.
- R9: br_taken_o is high only when branch_i is high and the selected condition is met. When branch_i is low, br_taken_o is 0 whatever the operand values.
- R10: PC+4 and the branch target wrap modulo 2^32 and do not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Instruction word; [25:0] jump index, [15:0] branch offset |
| jump_i | input | 1 | Instruction is a direct jump |
| branch_i | input | 1 | Instruction is a conditional branch |
| br_type_i | input | 2 | Condition code: 00 eq, 01 ne, 10 le-zero, 11 gt-zero |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| next_pc_o | output | 32 | Selected next program counter |
| br_taken_o | output | 1 | Branch flag set and condition met |

## Verification
The checker uses immediate assertions and assumes that every input holds a known value. It skips evaluation while any input is X, so time zero raises no false failure. The stimulus always drives every input with a full defined value: random 32-bit words from a fixed seed, plus directed words for the corner cases. These cover equal operands, signed zero, the most negative value, a PC+4 carry into the top nibble, wrap past 2^32, and jump and branch both set.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    BR_EQ  = 2'b00,
    BR_NE  = 2'b01,
    BR_LEZ = 2'b10,
    BR_GTZ = 2'b11
  } br_kind_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  input  br_kind_e        kind_i,
  input  logic            en_i,
  output logic            taken_o
);
  logic is_eq, is_zero, is_neg, cond;

  assign is_eq   = (rs_i == rt_i);
  assign is_zero = (rs_i == '0);
  assign is_neg  = rs_i[XLEN-1];

  always_comb begin
    unique case (kind_i)
      BR_EQ:   cond = is_eq;
      BR_NE:   cond = !is_eq;
      BR_LEZ:  cond = is_neg || is_zero;
      BR_GTZ:  cond = !is_neg && !is_zero;
      default: cond = 1'b0;
    endcase
  end

  assign taken_o = en_i && cond;
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  output logic [XLEN-1:0] seq_pc_o,
  output logic [XLEN-1:0] br_tgt_o,
  output logic [XLEN-1:0] jmp_tgt_o
);
  localparam int unsigned HI_W  = XLEN - JIDX_W - 2;
  localparam int unsigned EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] step, br_off;
  logic [IMM_W-1:0] imm;

  assign step = XLEN'(4);
  assign imm  = instr_i[IMM_W-1:0];

  assign seq_pc_o  = pc_i + step;
  assign br_off    = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign br_tgt_o  = seq_pc_o + br_off;
  // upper bits come from the sequential address, not the current one
  assign jmp_tgt_o = {seq_pc_o[XLEN-1 -: HI_W], instr_i[JIDX_W-1:0], 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] seq_pc_i,
  input  logic [XLEN-1:0] br_tgt_i,
  input  logic [XLEN-1:0] jmp_tgt_i,
  input  logic            br_taken_i,
  input  logic            jump_i,
  output logic [XLEN-1:0] next_pc_o
);
  logic [XLEN-1:0] lvl2;

  assign lvl2      = br_taken_i ? br_tgt_i : seq_pc_i;
  assign next_pc_o = jump_i ? jmp_tgt_i : lvl2;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic            jump_i,
  input  logic            branch_i,
  input  logic [1:0]      br_type_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            br_taken_o
);
  logic [XLEN-1:0] seq_pc, br_tgt, jmp_tgt;
  logic            taken;

  npc_cond_eval #(.XLEN(XLEN)) i_cond (
    .rs_i    (rs_val_i),
    .rt_i    (rt_val_i),
    .kind_i  (br_kind_e'(br_type_i)),
    .en_i    (branch_i),
    .taken_o (taken)
  );

  npc_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) i_tgt (
    .pc_i      (pc_i),
    .instr_i   (instr_i),
    .seq_pc_o  (seq_pc),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  npc_select #(.XLEN(XLEN)) i_sel (
    .seq_pc_i   (seq_pc),
    .br_tgt_i   (br_tgt),
    .jmp_tgt_i  (jmp_tgt),
    .br_taken_i (taken),
    .jump_i     (jump_i),
    .next_pc_o  (next_pc_o)
  );

  assign br_taken_o = taken;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned JIDX_W = 26
) (
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic            jump_i,
  input logic            branch_i,
  input logic [1:0]      br_type_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            br_taken_o
);
  logic known;
  assign known = !$isunknown({pc_i, instr_i, jump_i, branch_i, br_type_i, rs_val_i, rt_val_i});

  always_comb begin
    if (known) begin
      a_r9_no_take_without_branch: assert (branch_i || !br_taken_o);
      a_r4_fallthrough: assert (jump_i || br_taken_o || next_pc_o == pc_i + XLEN'(4));
      a_r1_jump_index: assert (!jump_i || next_pc_o[JIDX_W+1:0] == {instr_i[JIDX_W-1:0], 2'b00});
      a_r5_eq_taken: assert (!(branch_i && br_type_i == 2'b00 && rs_val_i == rt_val_i) || br_taken_o);
      a_r6_ne_taken: assert (!(branch_i && br_type_i == 2'b01 && rs_val_i == rt_val_i) || !br_taken_o);
      a_r8_gtz_sign: assert (!(br_taken_o && br_type_i == 2'b11) || !rs_val_i[XLEN-1]);
      a_r7_lez_sign: assert (!(branch_i && br_type_i == 2'b10 && rs_val_i[XLEN-1]) || br_taken_o);
      a_r2_branch_aligned: assert (jump_i || !br_taken_o || next_pc_o[1:0] == pc_i[1:0]);
    end
  end
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .JIDX_W(JIDX_W)) i_npc_unit_chk (
  .pc_i       (pc_i),
  .instr_i    (instr_i),
  .jump_i     (jump_i),
  .branch_i   (branch_i),
  .br_type_i  (br_type_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .next_pc_o  (next_pc_o),
  .br_taken_o (br_taken_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc, instr, rs, rt, next_pc;
  logic        jump, branch, taken;
  logic [1:0]  btype;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  npc_unit i_npc_unit (
    .pc_i(pc), .instr_i(instr), .jump_i(jump), .branch_i(branch),
    .br_type_i(btype), .rs_val_i(rs), .rt_val_i(rt),
    .next_pc_o(next_pc), .br_taken_o(taken)
  );

  function automatic bit ref_cond(logic [1:0] t, logic [31:0] a, logic [31:0] b);
    case (t)
      2'b00:   return a == b;
      2'b01:   return a != b;
      2'b10:   return $signed(a) <= 0;
      default: return $signed(a) > 0;
    endcase
  endfunction

  function automatic bit ref_taken();
    return branch && ref_cond(btype, rs, rt);
  endfunction

  function automatic logic [31:0] ref_next();
    logic [31:0] s;
    s = pc + 32'd4;
    if (jump) return {s[31:28], instr[25:0], 2'b00};
    if (ref_taken()) return s + {{14{instr[15]}}, instr[15:0], 2'b00};
    return s;
  endfunction

  task automatic drive(input logic [31:0] p, input logic [31:0] w, input logic j,
                       input logic b, input logic [1:0] t,
                       input logic [31:0] a, input logic [31:0] c);
    @(negedge clk);
    pc = p; instr = w; jump = j; branch = b; btype = t; rs = a; rt = c;
    #1;
  endtask

  task automatic check(input string req);
    logic [31:0] en;
    bit et;
    en = ref_next();
    et = ref_taken();
    checks++;
    if (next_pc !== en || taken !== et) begin
      errors++;
      $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
               req, next_pc, taken, en, et);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    pc = '0; instr = '0; jump = 0; branch = 0; btype = 0; rs = '0; rt = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-time quiescent inputs
    drive(32'h0, 32'h0, 0, 0, 2'b00, 32'h0, 32'h0); check("R4 R9 idle");
    // R1: PC+4 carries into top nibble
    drive(32'h0FFF_FFFC, 32'h03AB_CDEF, 1, 0, 2'b00, 0, 1); check("R1 carry");
    // R3: jump wins over taken branch
    drive(32'h0000_1000, 32'h0000_0010, 1, 1, 2'b00, 5, 5); check("R3 priority");
    // R5 / R6
    drive(32'h0000_2000, 32'h0000_0008, 0, 1, 2'b00, 7, 7); check("R5 eq taken");
    drive(32'h0000_2000, 32'h0000_0008, 0, 1, 2'b00, 7, 8); check("R5 eq not taken");
    drive(32'h0000_2000, 32'h0000_0008, 0, 1, 2'b01, 7, 8); check("R6 ne taken");
    drive(32'h0000_2000, 32'h0000_0008, 0, 1, 2'b01, 9, 9); check("R6 ne not taken");
    // R7 / R8 sign corners, rt differing
    drive(32'h100, 32'h0000_FFFF, 0, 1, 2'b10, 32'h0, 32'hDEAD); check("R7 zero");
    drive(32'h100, 32'h0000_FFFF, 0, 1, 2'b10, 32'h8000_0000, 32'h0); check("R7 min neg");
    drive(32'h100, 32'h0000_FFFF, 0, 1, 2'b10, 32'h1, 32'h0); check("R7 positive");
    drive(32'h100, 32'h0000_0004, 0, 1, 2'b11, 32'h1, 32'hFFFF_FFFF); check("R8 one");
    drive(32'h100, 32'h0000_0004, 0, 1, 2'b11, 32'h0, 32'h5); check("R8 zero");
    drive(32'h100, 32'h0000_0004, 0, 1, 2'b11, 32'hFFFF_FFFF, 32'h5); check("R8 neg");
    // R9: conditions met but branch flag low
    drive(32'h400, 32'h0000_0020, 0, 0, 2'b00, 3, 3); check("R9 flag low");
    // R2: negative offset; R10: wrap
    drive(32'h0000_0010, 32'h0000_8000, 0, 1, 2'b00, 1, 1); check("R2 neg offset");
    drive(32'hFFFF_FFFC, 32'h0, 0, 0, 2'b00, 0, 1); check("R10 seq wrap");
    drive(32'hFFFF_FFF0, 32'h0000_0010, 0, 1, 2'b01, 0, 1); check("R10 branch wrap");
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = $urandom();
      drive($urandom(), $urandom(), ($urandom() % 4) == 0, $urandom(),
            2'($urandom()), a, ($urandom() % 3 == 0) ? a : $urandom());
      check("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule